// File: doc/BRIEF.md
# Flash Row Burst Assembly Buffer

This block gathers one row of flash write data before it is committed to the array in a single programming step. A command decoder in front of it issues three kinds of load strobe. An opening load carries an explicit byte address: the bits above the low offset field select the destination row, and the offset field itself must be zero. Middle loads all arrive at one fixed command address, and an internal byte pointer moves by two after each. A closing load supplies the final word and starts the row program on its own, with no further command.

With the default offset field of six bits, a row holds 32 words of 16 bits, so destinations fall on multiples of 40h. The array is a behavioural model in which erased cells read as zero and programming can only set bits. Programming is therefore the bitwise OR of the staged row into the array row. After a commit, a programming window lasts a set number of cycles. During that window reads return a fixed placeholder and new loads are ignored. A burst that is malformed in any way is dropped, and it raises a sticky error flag.

Top module: `burst_stage`

## Requirements
- R1: After reset every array word reads 0, and busy, prog_active and burst_err are all 0.
- R2: An opening load whose address has a zero offset field (bits OFS_W-1:0) starts a burst. It latches the row from address bits ADDR_W-1:OFS_W and stores its data as word 0.
- R3: An opening load with a nonzero offset field sets burst_err and leaves no burst open (busy 0).
- R4: Middle loads put their data into words 1, 2, 3 and on in arrival order, whatever address they carry.
- R5: A closing load that arrives when exactly WORDS-1 words are held supplies the last word. On that edge it ORs all WORDS words into the latched row. prog_active is 1 in the cycle after the closing load.
- R6: prog_active stays 1 for exactly PROG_CYCLES cycles after a commit.
- R7: While prog_active is 1, rd_data equals HOLD_VAL. Otherwise it is the array word at byte address rd_addr (bit 0 ignored).
- R8: Committing a row again ORs the new data into the old contents.
- R9: Loads of any kind that arrive while prog_active is 1 have no effect on the burst or on burst_err.
- R10: Any of the following sets burst_err, closes the burst and programs nothing: a closing load with a word count other than WORDS-1, a middle load when WORDS-1 words are already held, or a middle or closing load with no open burst.
- R11: burst_err stays set until a valid opening load clears it.
- R12: An opening load while a burst is open discards the partial burst and restarts at the new row.
- R13: busy is 1 while a burst is open or a row is being programmed.
- R14: Strobes that arrive together are resolved by priority: opening first, then closing, then middle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_first | input | 1 | Opening load strobe |
| ld_next | input | 1 | Middle load strobe |
| ld_store | input | 1 | Closing load strobe, starts the commit |
| ld_addr | input | ADDR_W | Byte address of the load |
| ld_data | input | DATA_W | Word carried by the load |
| rd_addr | input | ADDR_W | Byte address for array reads |
| rd_data | output | DATA_W | Array read data, or HOLD_VAL while programming |
| busy | output | 1 | Burst open or programming in progress |
| prog_active | output | 1 | Programming window active |
| burst_err | output | 1 | Sticky malformed-burst flag |

## Verification
The bench builds the block with ADDR_W=9, which gives eight rows. Every row can then be compared word by word, and restarted or repeated bursts can be aimed at rows that are known to be untouched. PROG_CYCLES=5 keeps the programming window short, so its exact length is counted on every commit. It still leaves room to inject stray loads inside the window. HOLD_VAL=16'hDEAD differs from both erased cells and the test patterns, so masked reads can be told apart from real ones.

// File: rtl/burst_pkg.sv
package burst_pkg;

    // Kind of load presented in a cycle, after priority resolution
    typedef enum logic [1:0] {
        LD_NONE  = 2'd0,
        LD_FIRST = 2'd1,
        LD_NEXT  = 2'd2,
        LD_STORE = 2'd3
    } load_kind_e;

    // Outcome of a load for the fill controller
    typedef enum logic [2:0] {
        EV_NONE   = 3'd0,
        EV_OPEN   = 3'd1,
        EV_APPEND = 3'd2,
        EV_COMMIT = 3'd3,
        EV_FAULT  = 3'd4
    } fill_event_e;

    // Opening beats closing beats middle
    function automatic load_kind_e pick_load(input logic first, input logic nxt,
                                             input logic store);
        if (first)      return LD_FIRST;
        else if (store) return LD_STORE;
        else if (nxt)   return LD_NEXT;
        else            return LD_NONE;
    endfunction

    // Byte pointer step for one 16-bit word
    localparam int unsigned PTR_STEP = 2;

endpackage

// File: rtl/burst_fill_ctrl.sv
module burst_fill_ctrl
    import burst_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int OFS_W  = 6
) (
    input  logic                      clk,
    input  logic                      rst,
    input  load_kind_e                kind,
    input  logic [ADDR_W-1:0]         addr,
    input  logic                      hold,
    output logic                      buf_we,
    output logic [OFS_W-2:0]          buf_idx,
    output logic                      commit,
    output logic [ADDR_W-OFS_W-1:0]   row_q,
    output logic                      open_q,
    output logic                      err_q
);
    localparam int WORDS = 2 ** (OFS_W - 1);
    localparam int IDX_W = OFS_W - 1;
    localparam int ROW_W = ADDR_W - OFS_W;

    logic [OFS_W-1:0] ptr_q;      // byte pointer into the staging row
    logic [IDX_W-1:0] held;       // words currently held
    fill_event_e      ev;

    assign held = ptr_q[OFS_W-1:1];

    always_comb begin
        ev = EV_NONE;
        if (!hold) begin
            unique case (kind)
                LD_FIRST: ev = (addr[OFS_W-1:0] == '0) ? EV_OPEN : EV_FAULT;
                LD_NEXT:  ev = (open_q && held <= IDX_W'(WORDS - 2)) ? EV_APPEND : EV_FAULT;
                LD_STORE: ev = (open_q && held == IDX_W'(WORDS - 1)) ? EV_COMMIT : EV_FAULT;
                default:  ev = EV_NONE;
            endcase
        end
    end

    assign buf_we  = (ev == EV_OPEN) || (ev == EV_APPEND);
    assign buf_idx = (ev == EV_OPEN) ? '0 : held;
    assign commit  = (ev == EV_COMMIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q  <= '0;
            row_q  <= '0;
            open_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            unique case (ev)
                EV_OPEN: begin
                    open_q <= 1'b1;
                    err_q  <= 1'b0;
                    ptr_q  <= OFS_W'(PTR_STEP);
                    row_q  <= addr[ADDR_W-1:OFS_W];
                end
                EV_APPEND: ptr_q  <= ptr_q + OFS_W'(PTR_STEP);
                EV_COMMIT: begin
                    open_q <= 1'b0;
                    ptr_q  <= '0;
                end
                EV_FAULT: begin
                    open_q <= 1'b0;
                    err_q  <= 1'b1;
                    ptr_q  <= '0;
                end
                default: ;
            endcase
        end
    end

    logic unused_row_w;
    assign unused_row_w = (ROW_W > 0);

endmodule

// File: rtl/burst_buffer.sv
module burst_buffer #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 31,
    parameter int IDX_W  = 5
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    we,
    input  logic [IDX_W-1:0]        idx,
    input  logic [DATA_W-1:0]       wdata,
    output logic [DEPTH*DATA_W-1:0] words
);
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [DATA_W-1:0] slot_q;
        always_ff @(posedge clk) begin
            if (rst)
                slot_q <= '0;
            else if (we && idx == IDX_W'(g))
                slot_q <= wdata;
        end
        assign words[g*DATA_W +: DATA_W] = slot_q;
    end
endmodule

// File: rtl/burst_array.sv
module burst_array #(
    parameter int                DATA_W      = 16,
    parameter int                ADDR_W      = 10,
    parameter int                OFS_W       = 6,
    parameter int                PROG_CYCLES = 8,
    parameter logic [DATA_W-1:0] HOLD_VAL    = '1
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  commit,
    input  logic [ADDR_W-OFS_W-1:0]               row,
    input  logic [(2**(OFS_W-1))*DATA_W-1:0]      row_data,
    input  logic [ADDR_W-1:0]                     rd_addr,
    output logic [DATA_W-1:0]                     rd_data,
    output logic                                  prog_active
);
    localparam int WORDS = 2 ** (OFS_W - 1);
    localparam int IDX_W = OFS_W - 1;
    localparam int CELLS = (2 ** (ADDR_W - OFS_W)) * WORDS;
    localparam int TMR_W = $clog2(PROG_CYCLES + 1);

    logic [DATA_W-1:0] mem [CELLS];
    logic [TMR_W-1:0]  tmr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < CELLS; c++) mem[c] <= '0;
            tmr_q <= '0;
        end else begin
            if (commit) begin
                for (int w = 0; w < WORDS; w++)
                    mem[{row, IDX_W'(w)}] <= mem[{row, IDX_W'(w)}]
                                           | row_data[w*DATA_W +: DATA_W];
                tmr_q <= TMR_W'(PROG_CYCLES);
            end else if (tmr_q != '0) begin
                tmr_q <= tmr_q - TMR_W'(1);
            end
        end
    end

    assign prog_active = (tmr_q != '0);
    assign rd_data     = prog_active ? HOLD_VAL : mem[rd_addr[ADDR_W-1:1]];

    logic unused_rd_lsb;
    assign unused_rd_lsb = rd_addr[0];

endmodule

// File: rtl/burst_stage.sv
module burst_stage
    import burst_pkg::*;
#(
    parameter int                DATA_W      = 16,
    parameter int                ADDR_W      = 10,
    parameter int                OFS_W       = 6,
    parameter int                PROG_CYCLES = 8,
    parameter logic [DATA_W-1:0] HOLD_VAL    = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_first,
    input  logic              ld_next,
    input  logic              ld_store,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              prog_active,
    output logic              burst_err
);
    localparam int WORDS = 2 ** (OFS_W - 1);
    localparam int IDX_W = OFS_W - 1;
    localparam int ROW_W = ADDR_W - OFS_W;

    load_kind_e                kind;
    logic                      buf_we;
    logic [IDX_W-1:0]          buf_idx;
    logic                      commit;
    logic [ROW_W-1:0]          row_q;
    logic                      open_q;
    logic [(WORDS-1)*DATA_W-1:0] staged;
    logic [WORDS*DATA_W-1:0]   row_data;

    assign kind = pick_load(ld_first, ld_next, ld_store);

    burst_fill_ctrl #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .kind    (kind),
        .addr    (ld_addr),
        .hold    (prog_active),
        .buf_we  (buf_we),
        .buf_idx (buf_idx),
        .commit  (commit),
        .row_q   (row_q),
        .open_q  (open_q),
        .err_q   (burst_err)
    );

    burst_buffer #(.DATA_W(DATA_W), .DEPTH(WORDS - 1), .IDX_W(IDX_W)) u_buf (
        .clk   (clk),
        .rst   (rst),
        .we    (buf_we),
        .idx   (buf_idx),
        .wdata (ld_data),
        .words (staged)
    );

    // Last word bypasses the buffer so the commit uses the closing load directly
    for (genvar g = 0; g < WORDS; g++) begin : g_row
        if (g == WORDS - 1) begin : g_last
            assign row_data[g*DATA_W +: DATA_W] = ld_data;
        end else begin : g_held
            assign row_data[g*DATA_W +: DATA_W] = staged[g*DATA_W +: DATA_W];
        end
    end

    burst_array #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .OFS_W(OFS_W),
        .PROG_CYCLES(PROG_CYCLES), .HOLD_VAL(HOLD_VAL)
    ) u_arr (
        .clk         (clk),
        .rst         (rst),
        .commit      (commit),
        .row         (row_q),
        .row_data    (row_data),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .prog_active (prog_active)
    );

    assign busy = open_q | prog_active;

endmodule

// File: rtl/burst_stage_chk.sv
module burst_stage_chk #(
    parameter int DATA_W      = 16,
    parameter int ADDR_W      = 10,
    parameter int OFS_W       = 6,
    parameter int PROG_CYCLES = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              ld_first,
    input logic              ld_store,
    input logic [ADDR_W-1:0] ld_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic              prog_active,
    input logic              burst_err
);
    localparam int CNT_W = $clog2(PROG_CYCLES + 1) + 1;

    logic [CNT_W-1:0] hold_cnt;
    always_ff @(posedge clk) begin
        if (rst || !prog_active) hold_cnt <= '0;
        else                     hold_cnt <= hold_cnt + CNT_W'(1);
    end

    assert_prog_after_store_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(prog_active) |-> $past(ld_store));

    assert_window_bound_R6: assert property (@(posedge clk) disable iff (rst)
        prog_active |-> hold_cnt < CNT_W'(PROG_CYCLES));

    assert_window_len_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(prog_active) |-> hold_cnt == CNT_W'(PROG_CYCLES));

    assert_read_masked_R7: assert property (@(posedge clk) disable iff (rst)
        (prog_active && $past(prog_active)) |-> $stable(rd_data));

    assert_bad_start_R3: assert property (@(posedge clk) disable iff (rst)
        (ld_first && ld_addr[OFS_W-1:0] != '0 && !prog_active) |=> burst_err);

    assert_ignore_loads_R9: assert property (@(posedge clk) disable iff (rst)
        prog_active |=> $stable(burst_err));

    assert_fault_no_prog_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(burst_err) |-> !$rose(prog_active));

endmodule

bind burst_stage burst_stage_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .OFS_W(OFS_W), .PROG_CYCLES(PROG_CYCLES)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ld_first    (ld_first),
    .ld_store    (ld_store),
    .ld_addr     (ld_addr),
    .rd_data     (rd_data),
    .prog_active (prog_active),
    .burst_err   (burst_err)
);

// File: tb/burst_stage_test.sv
module burst_stage_test;
    localparam int          DATA_W = 16;
    localparam int          ADDR_W = 9;
    localparam int          OFS_W  = 6;
    localparam int          PCYC   = 5;
    localparam logic [15:0] HOLD   = 16'hDEAD;
    localparam int          WORDS  = 32;
    localparam int          ROWS   = 8;
    localparam logic [ADDR_W-1:0] CMD_ADDR = 9'h0F2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ld_first = 1'b0, ld_next = 1'b0, ld_store = 1'b0;
    logic [ADDR_W-1:0] ld_addr = '0;
    logic [DATA_W-1:0] ld_data = '0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [DATA_W-1:0] rd_data;
    logic              busy, prog_active, burst_err;

    int nchk = 0;
    int nerr = 0;
    logic [15:0] exp_mem [ROWS*WORDS];

    burst_stage #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .OFS_W(OFS_W),
        .PROG_CYCLES(PCYC), .HOLD_VAL(HOLD)
    ) uut (
        .clk(clk), .rst(rst), .ld_first(ld_first), .ld_next(ld_next),
        .ld_store(ld_store), .ld_addr(ld_addr), .ld_data(ld_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy),
        .prog_active(prog_active), .burst_err(burst_err)
    );

    always #2 clk = ~clk;

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    function automatic logic [15:0] pat(int row, int w, int seed);
        return 16'((row * 4099 + w * 257 + seed * 8191) ^ (w << 9) ^ seed);
    endfunction

    function automatic logic [ADDR_W-1:0] row_addr(int row);
        return ADDR_W'(row << OFS_W);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Present strobes at a falling edge, let one rising edge take them
    task automatic strobe(logic f, logic n, logic s, logic [ADDR_W-1:0] a, logic [15:0] d);
        ld_first = f; ld_next = n; ld_store = s; ld_addr = a; ld_data = d;
        @(negedge clk);
        ld_first = 1'b0; ld_next = 1'b0; ld_store = 1'b0;
    endtask

    task automatic read_word(logic [ADDR_W-1:0] a, output logic [15:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic check_row(string req, int row);
        logic [15:0] v;
        int bad = 0;
        for (int w = 0; w < WORDS; w++) begin
            read_word(ADDR_W'((row << OFS_W) + 2 * w + (w & 1)), v);
            if (v !== exp_mem[row*WORDS + w]) begin
                bad++;
                $display("FAIL %s: row %0d word %0d actual=%h expected=%h",
                         req, row, w, v, exp_mem[row*WORDS + w]);
            end
        end
        nchk++;
        if (bad != 0) nerr++;
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (prog_active && guard < 100) begin
            @(negedge clk);
            guard++;
        end
    endtask

    // Full burst; poke injects stray loads during the programming window
    task automatic run_burst(int row, int seed, bit poke);
        logic [15:0] v;
        int len;
        strobe(1, 0, 0, row_addr(row), pat(row, 0, seed));
        check("R2 open burst busy", busy, 1);
        check("R2 open burst no error", burst_err, 0);
        for (int w = 1; w < WORDS - 1; w++)
            strobe(0, 1, 0, CMD_ADDR ^ ADDR_W'(w), pat(row, w, seed));   // R4 address ignored
        check("R13 busy while filling", busy, 1);
        strobe(0, 0, 1, '0, pat(row, WORDS - 1, seed));
        for (int w = 0; w < WORDS; w++)
            exp_mem[row*WORDS + w] = exp_mem[row*WORDS + w] | pat(row, w, seed);
        check("R5 prog_active after store", prog_active, 1);
        check("R13 busy while programming", busy, 1);
        check("R10 no error on good burst", burst_err, 0);
        read_word(row_addr(row), v);
        check("R7 read masked during program", v, HOLD);
        if (poke) begin
            strobe(0, 1, 0, CMD_ADDR, 16'h1234);
            strobe(1, 0, 0, row_addr((row + 1) % ROWS), 16'h5678);
            wait_idle();
            check("R9 no error from ignored loads", burst_err, 0);
            check("R9 opening load ignored, no burst open", busy, 0);
        end else begin
            len = 1;
            while (1) begin
                @(negedge clk);
                if (!prog_active || len > 50) break;
                len++;
            end
            check("R6 program window length", len, PCYC);
            check("R13 busy drops after program", busy, 0);
        end
        check_row("R5 row contents after commit", row);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        check("R1 busy after reset", busy, 0);
        check("R1 prog_active after reset", prog_active, 0);
        check("R1 burst_err after reset", burst_err, 0);
        read_word(9'h000, v); check("R1 erased word row0", v, 0);
        read_word(9'h1FE, v); check("R1 erased word last", v, 0);
    endtask

    task automatic t_bad_first();
        strobe(1, 0, 0, row_addr(2) | 9'h004, 16'hAAAA);
        check("R3 misaligned open sets error", burst_err, 1);
        check("R3 misaligned open leaves no burst", busy, 0);
        check("R3 no programming started", prog_active, 0);
        strobe(1, 0, 0, row_addr(2), 16'h0001);
        check("R11 valid open clears error", burst_err, 0);
        check("R11 valid open starts burst", busy, 1);
    endtask

    task automatic t_short_store();
        strobe(1, 0, 0, row_addr(3), 16'hFFFF);
        for (int w = 1; w < 6; w++) strobe(0, 1, 0, CMD_ADDR, 16'hFFFF);
        strobe(0, 0, 1, '0, 16'hFFFF);
        check("R10 short store sets error", burst_err, 1);
        check("R10 short store closes burst", busy, 0);
        check("R10 short store no program", prog_active, 0);
        check_row("R10 row untouched after short store", 3);
        strobe(0, 1, 0, CMD_ADDR, 16'h0F0F);
        check("R11 error stays set", burst_err, 1);
    endtask

    task automatic t_overrun();
        strobe(1, 0, 0, row_addr(4), 16'hFFFF);
        for (int w = 1; w < WORDS - 1; w++) strobe(0, 1, 0, CMD_ADDR, 16'hFFFF);
        check("R10 thirty middle loads accepted", burst_err, 0);
        strobe(0, 1, 0, CMD_ADDR, 16'hFFFF);
        check("R10 middle load past limit sets error", burst_err, 1);
        check("R10 overrun closes burst", busy, 0);
        strobe(0, 0, 1, '0, 16'hFFFF);
        check("R10 store after overrun no program", prog_active, 0);
        check_row("R10 row untouched after overrun", 4);
    endtask

    task automatic t_orphan();
        strobe(1, 0, 0, row_addr(0), 16'h0);
        strobe(0, 0, 1, '0, 16'h0);
        check("R10 early store error", burst_err, 1);
        strobe(0, 0, 1, '0, 16'hFFFF);
        check("R10 orphan store no program", prog_active, 0);
        check("R10 orphan store keeps error", burst_err, 1);
    endtask

    task automatic t_restart();
        strobe(1, 0, 0, row_addr(5), 16'hFFFF);
        for (int w = 1; w < 4; w++) strobe(0, 1, 0, CMD_ADDR, 16'hFFFF);
        run_burst(6, 3, 0);
        check_row("R12 abandoned row untouched", 5);
    endtask

    task automatic t_priority();
        strobe(1, 0, 0, row_addr(1), 16'hFFFF);
        for (int w = 1; w < 4; w++) strobe(0, 1, 0, CMD_ADDR, 16'hFFFF);
        strobe(1, 1, 1, row_addr(7), pat(7, 0, 9));
        check("R14 opening wins over store and middle", burst_err, 0);
        check("R14 burst still open", busy, 1);
        check("R14 no program started", prog_active, 0);
        for (int w = 1; w < WORDS - 1; w++) strobe(0, 1, 0, CMD_ADDR, pat(7, w, 9));
        strobe(0, 0, 1, '0, pat(7, WORDS - 1, 9));
        for (int w = 0; w < WORDS; w++)
            exp_mem[7*WORDS + w] = exp_mem[7*WORDS + w] | pat(7, w, 9);
        check("R14 burst completes at new row", prog_active, 1);
        wait_idle();
        check_row("R14 new row contents", 7);
        check_row("R14 old row untouched", 1);
    endtask

    initial begin
        for (int i = 0; i < ROWS*WORDS; i++) exp_mem[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        run_burst(0, 1, 0);
        run_burst(0, 2, 0);          // R8 OR into existing row
        check_row("R8 second commit ORs", 0);
        t_bad_first();
        t_short_store();
        t_overrun();
        t_orphan();
        t_restart();
        run_burst(2, 4, 1);          // R9 loads during window
        t_priority();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule